// File: doc/BRIEF.md
# Password-Guarded Watchdog Timer

This block is a 16-bit up-counting watchdog for a microcontroller system. It advances once per prescaler tick. The tick comes from the system bus clock divided by 256 or by 16384. Software keeps it alive by servicing it through its control register. That register accepts changes only through a two-write sequence. The first write presents a password, made of a fixed low byte plus a byte that software can program. The write right after it must carry the correct guard pattern. Only then do the carried fields take effect.

The block owns an end-of-initialization bit. While that bit is set, other protected registers of the chip may not be written, and the block reports each change of the bit. There are three operating modes:
- time-out: the end-of-initialization bit is clear, and the counter starts from a fixed seed.
- normal: the bit is set, and the counter restarts from a reload value that software programs.
- prewarning: entered on any overflow or access error. The counter starts from a second fixed seed, and its overflow requests a system reset.

A second reset request that arrives before the first has been acknowledged is flagged as a double reset.

Top module: `wdog_guard`

## Requirements
- R1: After reset the counter holds 0xFFFC, the mode is time-out, end-of-initialization is 0, and prewarning, reset request, pending, double-reset and access-error outputs are all 0.
- R2: Each counting step takes 256 clocks when divider select (bit 3 of the modify write) is 0, and 16384 clocks when it is 1. The step is counted from the cycle the counter was last loaded.
- R3: A write made with no window open is a password write. It is accepted only if bits 7:0 equal 0x3C and bits 15:8 equal the stored user password, which resets to 0x00. Any other value pulses accErr for one cycle.
- R4: An accepted password opens a window for exactly one following access. If that access is a control write with bits 1:0 = 2'b01, it is a valid modify. If it is a control write with other guard bits, or a protected-register access, it pulses accErr. The window closes after that access either way.
- R5: A valid modify sets end-of-initialization from bit 2. If bit 2 is 1, the block enters normal mode and loads the reload value into the counter. If bit 2 is 0, the block enters time-out mode and loads 0xFFFC.
- R6: A modify write carries four configuration fields: the reload value (bits 31:16), a new user password (bits 15:8), divider select (bit 3) and disable (bit 4). They are stored only if end-of-initialization was 0 before that modify. Otherwise the counter is reloaded from the stored reload value.
- R7: protGrant is high only when protWr is high, end-of-initialization is 0 and no window is open. A protected access made while end-of-initialization is 1 pulses accErr.
- R8: endInitEvt pulses for one cycle, in the same cycle end-of-initialization takes a new value, and only when the value differs from the old one.
- R9: An access error, or a counter overflow in normal or time-out mode, enters prewarning mode and loads 0xFFF0. While prewarning, a valid modify changes nothing.
- R10: An overflow in prewarning mode pulses resetReq for one cycle, returns to time-out mode with end-of-initialization 0 and the counter at 0xFFFC, and sets resetPend. The reset then follows 4096 clocks after prewarning entry at divider 256. resetPend stays set until rstClr.
- R11: A reset request made while resetPend is set raises dblRst, which stays set until rstN.
- R12: The disable field stops the counter in normal mode only. Access errors are still detected and prewarning still counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 32 | Control register write data |
| protWr | input | 1 | Access to some other protected register |
| rstClr | input | 1 | Acknowledge of a watchdog reset, clears resetPend |
| protGrant | output | 1 | Protected access is allowed |
| endInit | output | 1 | End-of-initialization bit |
| cntVal | output | 16 | Current counter value |
| inTimeout | output | 1 | Time-out mode active |
| preWarn | output | 1 | Prewarning mode active |
| accErr | output | 1 | One-cycle access error pulse |
| endInitEvt | output | 1 | One-cycle pulse on an end-of-initialization change |
| resetReq | output | 1 | One-cycle watchdog reset request |
| resetPend | output | 1 | A watchdog reset awaits acknowledge |
| dblRst | output | 1 | Sticky double-reset flag |

## Verification
The assertions assume two things about the inputs. First, wrEn and protWr are never high in the same cycle. Second, the system answers resetReq only through rstClr and never through rstN, so that dblRst and resetPend reflect the whole run. The stimulus drives every access as a single-cycle strobe between clock edges and never overlaps the two access kinds. It also leaves each prewarning period to run out into a reset request, rather than resetting the block from outside.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W  = 16;
  localparam int PWD_W  = 8;
  localparam int DATA_W = CNT_W + 2 * PWD_W;
  localparam int LOW_W  = 2 * PWD_W;

  localparam logic [PWD_W-1:0] FIXED_PWD    = 8'h3C;
  localparam logic [CNT_W-1:0] TIMEOUT_SEED = 16'hFFFC;
  localparam logic [CNT_W-1:0] PREWARN_SEED = 16'hFFF0;

  // modify-write field positions
  localparam int EI_BIT  = 2;
  localparam int SEL_BIT = 3;
  localparam int DIS_BIT = 4;
  localparam int PWD_LSB = PWD_W;
  localparam int RLD_LSB = LOW_W;
  localparam logic [1:0] GUARD_OK = 2'b01;

  typedef enum logic [1:0] {
    MODE_TIMEOUT = 2'd0,
    MODE_NORMAL  = 2'd1,
    MODE_PREWARN = 2'd2
  } wdMode_e;

  typedef struct packed {
    logic ldTimeout;
    logic ldPrewarn;
    logic ldReload;
    logic cfgWr;
    logic eiWr;
    logic eiVal;
    logic holdNormal;
  } dpStrobe_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int DIV_LO_LOG2 = 8,
  parameter int DIV_HI_LOG2 = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] newReload,
  input  logic [PWD_W-1:0] newPwd,
  input  logic             newSel,
  input  logic             newDis,
  output logic [CNT_W-1:0] cntVal,
  output logic             endInit,
  output logic [PWD_W-1:0] userPwd,
  output logic             ovf,
  output logic             endInitEvt
);
  localparam logic [DIV_HI_LOG2-1:0] PRE_ONE = DIV_HI_LOG2'(1);
  localparam logic [CNT_W-1:0]       CNT_ONE = CNT_W'(1);

  logic [DIV_HI_LOG2-1:0] preDiv;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-1:0]       reloadReg;
  logic [PWD_W-1:0]       userPwdReg;
  logic                   divSel;
  logic                   disReg;
  logic                   endInitReg;
  logic                   evtReg;
  logic                   tickLo;
  logic                   tickHi;
  logic                   tick;
  logic                   run;

  // prescaler taps; the slow tap needs more bits than the fast one
  generate
    if (DIV_HI_LOG2 > DIV_LO_LOG2) begin : g_taps
      assign tickLo = &preDiv[DIV_LO_LOG2-1:0];
      assign tickHi = &preDiv;
    end else begin : g_taps_same
      assign tickLo = &preDiv;
      assign tickHi = &preDiv;
    end
  endgenerate

  assign tick = divSel ? tickHi : tickLo;
  assign run  = !(stb.holdNormal && disReg);
  assign ovf  = run && tick && (&cnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= TIMEOUT_SEED;
      preDiv <= '0;
    end else if (stb.ldPrewarn) begin
      cnt    <= PREWARN_SEED;
      preDiv <= '0;
    end else if (stb.ldTimeout) begin
      cnt    <= TIMEOUT_SEED;
      preDiv <= '0;
    end else if (stb.ldReload) begin
      cnt    <= stb.cfgWr ? newReload : reloadReg;
      preDiv <= '0;
    end else if (run) begin
      preDiv <= preDiv + PRE_ONE;
      if (tick) cnt <= cnt + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadReg  <= '0;
      userPwdReg <= '0;
      divSel     <= 1'b0;
      disReg     <= 1'b0;
    end else if (stb.cfgWr) begin
      reloadReg  <= newReload;
      userPwdReg <= newPwd;
      divSel     <= newSel;
      disReg     <= newDis;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      endInitReg <= 1'b0;
      evtReg     <= 1'b0;
    end else begin
      evtReg <= stb.eiWr && (stb.eiVal != endInitReg);
      if (stb.eiWr) endInitReg <= stb.eiVal;
    end
  end

  assign cntVal     = cnt;
  assign endInit    = endInitReg;
  assign userPwd    = userPwdReg;
  assign endInitEvt = evtReg;
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [LOW_W-1:0] wrLow,
  input  logic             protWr,
  input  logic             rstClr,
  input  logic             ovf,
  input  logic             endInit,
  input  logic [PWD_W-1:0] userPwd,
  output dpStrobe_t        stb,
  output logic             inTimeout,
  output logic             preWarn,
  output logic             accErr,
  output logic             resetReq,
  output logic             resetPend,
  output logic             dblRst,
  output logic             protGrant
);
  wdMode_e mode;
  wdMode_e modeNext;
  logic    winOpen;
  logic    pwdOk;
  logic    guardOk;
  logic    pwdErr;
  logic    guardErr;
  logic    protErr;
  logic    modOk;
  logic    accErrNow;
  logic    rstFire;
  logic    toPre;
  logic    apply;
  logic    accErrQ;
  logic    resetReqQ;
  logic    pendQ;
  logic    dblQ;

  assign pwdOk    = (wrLow[PWD_W-1:0] == FIXED_PWD) && (wrLow[PWD_LSB +: PWD_W] == userPwd);
  assign guardOk  = (wrLow[1:0] == GUARD_OK);
  assign pwdErr   = wrEn && !winOpen && !pwdOk;
  assign guardErr = wrEn && winOpen && !guardOk;
  assign modOk    = wrEn && winOpen && guardOk;
  assign protErr  = protWr && (endInit || winOpen);
  assign accErrNow = pwdErr || guardErr || protErr;

  assign rstFire = (mode == MODE_PREWARN) && ovf;
  assign toPre   = !rstFire && (mode != MODE_PREWARN) && (accErrNow || ovf);
  assign apply   = modOk && (mode != MODE_PREWARN) && !toPre;

  always_comb begin
    stb            = '0;
    stb.holdNormal = (mode == MODE_NORMAL);
    modeNext       = mode;
    if (rstFire) begin
      stb.ldTimeout = 1'b1;
      stb.eiWr      = 1'b1;
      stb.eiVal     = 1'b0;
      modeNext      = MODE_TIMEOUT;
    end else if (toPre) begin
      stb.ldPrewarn = 1'b1;
      modeNext      = MODE_PREWARN;
    end else if (apply) begin
      stb.eiWr      = 1'b1;
      stb.eiVal     = wrLow[EI_BIT];
      stb.ldReload  = wrLow[EI_BIT];
      stb.ldTimeout = !wrLow[EI_BIT];
      stb.cfgWr     = !endInit;
      modeNext      = wrLow[EI_BIT] ? MODE_NORMAL : MODE_TIMEOUT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_TIMEOUT;
      winOpen <= 1'b0;
    end else begin
      mode <= modeNext;
      if (wrEn)        winOpen <= !winOpen && pwdOk;
      else if (protWr) winOpen <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accErrQ   <= 1'b0;
      resetReqQ <= 1'b0;
      pendQ     <= 1'b0;
      dblQ      <= 1'b0;
    end else begin
      accErrQ   <= accErrNow;
      resetReqQ <= rstFire;
      if (rstFire)     pendQ <= 1'b1;
      else if (rstClr) pendQ <= 1'b0;
      if (rstFire && pendQ) dblQ <= 1'b1;
    end
  end

  assign inTimeout = (mode == MODE_TIMEOUT);
  assign preWarn   = (mode == MODE_PREWARN);
  assign accErr    = accErrQ;
  assign resetReq  = resetReqQ;
  assign resetPend = pendQ;
  assign dblRst    = dblQ;
  assign protGrant = protWr && !endInit && !winOpen;
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int DIV_LO_LOG2 = 8,
  parameter int DIV_HI_LOG2 = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              protWr,
  input  logic              rstClr,
  output logic              protGrant,
  output logic              endInit,
  output logic [CNT_W-1:0]  cntVal,
  output logic              inTimeout,
  output logic              preWarn,
  output logic              accErr,
  output logic              endInitEvt,
  output logic              resetReq,
  output logic              resetPend,
  output logic              dblRst
);
  dpStrobe_t        stb;
  logic             ovf;
  logic [PWD_W-1:0] userPwd;

  wdog_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrLow     (wrData[LOW_W-1:0]),
    .protWr    (protWr),
    .rstClr    (rstClr),
    .ovf       (ovf),
    .endInit   (endInit),
    .userPwd   (userPwd),
    .stb       (stb),
    .inTimeout (inTimeout),
    .preWarn   (preWarn),
    .accErr    (accErr),
    .resetReq  (resetReq),
    .resetPend (resetPend),
    .dblRst    (dblRst),
    .protGrant (protGrant)
  );

  wdog_datapath #(
    .DIV_LO_LOG2 (DIV_LO_LOG2),
    .DIV_HI_LOG2 (DIV_HI_LOG2)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .newReload  (wrData[RLD_LSB +: CNT_W]),
    .newPwd     (wrData[PWD_LSB +: PWD_W]),
    .newSel     (wrData[SEL_BIT]),
    .newDis     (wrData[DIS_BIT]),
    .cntVal     (cntVal),
    .endInit    (endInit),
    .userPwd    (userPwd),
    .ovf        (ovf),
    .endInitEvt (endInitEvt)
  );
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk
  import wdog_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             protGrant,
  input logic             endInit,
  input logic [CNT_W-1:0] cntVal,
  input logic             inTimeout,
  input logic             preWarn,
  input logic             accErr,
  input logic             endInitEvt,
  input logic             resetReq,
  input logic             resetPend,
  input logic             dblRst
);
  AST_PREWARN_SEED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(preWarn) |-> cntVal == PREWARN_SEED); // R9
  AST_ERR_TO_PREWARN: assert property (@(posedge clk) disable iff (!rstN)
    (accErr && !resetReq) |-> preWarn); // R9
  AST_RST_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (inTimeout && !endInit && cntVal == TIMEOUT_SEED && resetPend)); // R10
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq); // R10
  AST_DBL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    dblRst |=> dblRst); // R11
  AST_EVT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    endInitEvt |-> endInit != $past(endInit)); // R8
  AST_GRANT_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    protGrant |-> !endInit); // R7
endmodule

bind wdog_guard wdog_guard_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .protGrant  (protGrant),
  .endInit    (endInit),
  .cntVal     (cntVal),
  .inTimeout  (inTimeout),
  .preWarn    (preWarn),
  .accErr     (accErr),
  .endInitEvt (endInitEvt),
  .resetReq   (resetReq),
  .resetPend  (resetPend),
  .dblRst     (dblRst)
);

// File: tb/wdog_guard_tb_top.sv
module wdog_guard_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        protWr = 1'b0;
  logic        rstClr = 1'b0;
  logic        protGrant, endInit, inTimeout, preWarn, accErr, endInitEvt;
  logic        resetReq, resetPend, dblRst;
  logic [15:0] cntVal;

  always #5 clk = ~clk;

  wdog_guard dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .protWr(protWr),
    .rstClr(rstClr), .protGrant(protGrant), .endInit(endInit), .cntVal(cntVal),
    .inTimeout(inTimeout), .preWarn(preWarn), .accErr(accErr),
    .endInitEvt(endInitEvt), .resetReq(resetReq), .resetPend(resetPend),
    .dblRst(dblRst)
  );

  localparam int O_CNT = 0, O_EI = 1, O_TO = 2, O_PW = 3, O_AE = 4, O_EV = 5;
  localparam int O_RR = 6, O_RP = 7, O_DB = 8, O_PG = 9, O_EL = 10;

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } item_t;

  item_t       sbq[$];
  item_t       it;
  int          compared = 0;
  int          mismatched = 0;
  int unsigned cyc = 0;
  int unsigned lastElapsed = 0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] obs(int sel);
    case (sel)
      O_CNT:   return {16'h0, cntVal};
      O_EI:    return {31'h0, endInit};
      O_TO:    return {31'h0, inTimeout};
      O_PW:    return {31'h0, preWarn};
      O_AE:    return {31'h0, accErr};
      O_EV:    return {31'h0, endInitEvt};
      O_RR:    return {31'h0, resetReq};
      O_RP:    return {31'h0, resetPend};
      O_DB:    return {31'h0, dblRst};
      O_PG:    return {31'h0, protGrant};
      default: return lastElapsed;
    endcase
  endfunction

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      compared++;
      if (obs(it.sel) !== it.exp) begin
        mismatched++;
        $display("FAIL %s item %0d: actual %h expected %h", it.req, it.sel, obs(it.sel), it.exp);
      end
    end
  end

  task automatic expect_(string req, int sel, logic [31:0] exp);
    sbq.push_back('{req, sel, exp});
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ctlWrite(logic [31:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
    wrData = '0;
  endtask

  function automatic logic [31:0] pwdWord(logic [7:0] p);
    return {16'h0000, p, 8'h3C};
  endfunction

  function automatic logic [31:0] modWord(logic [15:0] rld, logic [7:0] p, logic [7:0] c);
    return {rld, p, c};
  endfunction

  task automatic waitHigh(int sel, int limit, int unsigned start);
    int n = 0;
    while (obs(sel) !== 32'd1 && n < limit) begin
      step(1);
      n++;
    end
    lastElapsed = cyc - start;
  endtask

  initial begin
    int unsigned entry;
    step(3);
    rstN = 1'b1;
    // R1 reset state
    expect_("R1", O_CNT, 32'hFFFC); expect_("R1", O_EI, 0); expect_("R1", O_TO, 1);
    expect_("R1", O_PW, 0); expect_("R1", O_RR, 0); expect_("R1", O_RP, 0);
    expect_("R1", O_DB, 0); expect_("R1", O_AE, 0);
    // R2 divide by 256
    step(255); expect_("R2", O_CNT, 32'hFFFC);
    step(1);   expect_("R2", O_CNT, 32'hFFFD);
    // R3 / R5 / R8 / R6 first configuration
    ctlWrite(pwdWord(8'h00)); expect_("R3", O_AE, 0);
    ctlWrite(modWord(16'hFF00, 8'h5A, 8'h05));
    expect_("R5", O_EI, 1); expect_("R5", O_TO, 0); expect_("R6", O_CNT, 32'hFF00);
    expect_("R8", O_EV, 1); expect_("R4", O_AE, 0);
    step(1); expect_("R8", O_EV, 0);
    // R3 old password rejected -> R9 prewarning
    ctlWrite(pwdWord(8'h00)); entry = cyc;
    expect_("R3", O_AE, 1); expect_("R9", O_PW, 1); expect_("R9", O_CNT, 32'hFFF0);
    // R4 protected access inside an open window
    ctlWrite(pwdWord(8'h5A)); expect_("R3", O_AE, 0);
    protWr = 1'b1; step(1); protWr = 1'b0;
    expect_("R4", O_AE, 1);
    // R9 modify ignored while prewarning
    ctlWrite(pwdWord(8'h5A));
    ctlWrite(modWord(16'h0000, 8'h5A, 8'h01));
    expect_("R9", O_EI, 1); expect_("R9", O_PW, 1); expect_("R9", O_EV, 0);
    // R10 reset after prewarning
    waitHigh(O_RR, 40000, entry);
    expect_("R10", O_EL, 4096); expect_("R10", O_RR, 1); expect_("R10", O_TO, 1);
    expect_("R10", O_EI, 0); expect_("R10", O_CNT, 32'hFFFC); expect_("R10", O_RP, 1);
    expect_("R8", O_EV, 1); expect_("R11", O_DB, 0);
    step(1); expect_("R10", O_RR, 0);
    // R4 bad guard bits -> R11 double reset
    ctlWrite(pwdWord(8'h5A));
    ctlWrite(modWord(16'h0000, 8'h5A, 8'h03)); entry = cyc;
    expect_("R4", O_AE, 1); expect_("R4", O_PW, 1);
    waitHigh(O_RR, 40000, entry);
    expect_("R10", O_EL, 4096); expect_("R11", O_DB, 1);
    // R10 acknowledge
    rstClr = 1'b1; step(1); rstClr = 1'b0;
    expect_("R10", O_RP, 0); expect_("R11", O_DB, 1);
    // R7 grant when unlocked
    protWr = 1'b1; expect_("R7", O_PG, 1);
    step(1); protWr = 1'b0; expect_("R7", O_AE, 0); expect_("R7", O_PW, 0);
    // R6 config applies only while unlocked
    ctlWrite(pwdWord(8'h5A));
    ctlWrite(modWord(16'hFFE0, 8'h5A, 8'h05)); expect_("R6", O_CNT, 32'hFFE0);
    ctlWrite(pwdWord(8'h5A));
    ctlWrite(modWord(16'h1234, 8'h5A, 8'h15)); entry = cyc;
    expect_("R6", O_CNT, 32'hFFE0); expect_("R8", O_EV, 0);
    step(256); expect_("R6", O_CNT, 32'hFFE1);
    // R9 normal-mode overflow
    waitHigh(O_PW, 40000, entry);
    expect_("R9", O_EL, 8192); expect_("R9", O_CNT, 32'hFFF0); expect_("R9", O_RR, 0);
    waitHigh(O_RR, 40000, cyc);
    step(1);
    // R12 disable freezes normal mode only
    ctlWrite(pwdWord(8'h5A));
    ctlWrite(modWord(16'hFFFE, 8'h5A, 8'h15));
    step(600); expect_("R12", O_CNT, 32'hFFFE); expect_("R12", O_PW, 0);
    protWr = 1'b1; expect_("R7", O_PG, 0);
    step(1); protWr = 1'b0;
    expect_("R12", O_AE, 1); expect_("R12", O_PW, 1);
    step(256); expect_("R12", O_CNT, 32'hFFF1);
    waitHigh(O_RR, 40000, cyc);
    step(1);
    // R2 divide by 16384
    ctlWrite(pwdWord(8'h5A));
    ctlWrite(modWord(16'hFFFE, 8'h5A, 8'h0D));
    step(16383); expect_("R2", O_CNT, 32'hFFFE);
    step(1);     expect_("R2", O_CNT, 32'hFFFF);
    @(negedge clk); #1;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule